// File: doc/BRIEF.md
# Sub-Word Access Widening Bridge

This bridge sits between a host port and a register space. The host port issues reads and writes of 1, 2 or 4 bytes at any byte offset. The register space accepts only aligned full-word accesses. The bridge decodes a 128-byte window into three targets: a bank of sixteen core registers, a bank of eight DMA registers and a single control register. It turns every host access into at most one aligned full-word access to the selected target.

A write that is narrower than a word, or that starts off a word boundary, becomes a read-merge-write. The bridge first fetches the current word through a side-effect-free peek port on the target. It then replaces only the bytes the host wrote and issues one full-word write. For a read, the bridge fetches the aligned word, shifts the addressed byte down to bit 0 and clears everything above the access size. Data is little-endian: host data byte k lands in byte lane (offset + k).

Each accepted request takes a fixed two cycles. The host raises `h_req` while the bridge is idle. The target strobe fires in the next cycle. `h_ready` pulses for one cycle after that, and `h_rdata` is valid during that pulse.

Top module: `swb_bridge`

## Requirements
- R1: An address below 0x40 selects the core bank at word index addr[5:2]. An address from 0x40 to 0x5F selects the DMA bank at word index (addr-0x40)>>2. The control register sits at 0x70. A full aligned write followed by a read returns the written word.
- R2: A write of size s at byte offset o = addr[1:0] replaces byte lanes o to min(o+s,4)-1 of the current word with host data bytes 0, 1 and so on. It keeps every other lane and writes the merged word, as a full word, to the target that the word-aligned address decodes to. Data bytes that fall past lane 3 are discarded.
- R3: The current word for the merge comes from the peek port. For addresses 0x00-0x3F it is the core word, for 0x40-0x5F the DMA word, for 0x60-0x73 the control register, and elsewhere it is zero. A narrow write never asserts a read strobe on any target, so a read-to-clear register is not disturbed by it.
- R4: A write whose word-aligned address is not 0x00-0x5F and not 0x70 is dropped with no target strobe. For example, a byte write at 0x61 or any write at 0x74-0x7F.
- R5: A read decodes the unaligned address, and the control register answers only at exactly 0x70. A read from any other address above 0x5F, including 0x71-0x73, returns 0 and strobes no target.
- R6: Read data is the fetched word shifted right by 8*addr[1:0] and masked to the low 8*size bits.
- R7: The size field `h_size` encodes 1, 2, 3 or 4 bytes directly. The values 0 and 5-7 act as 4.
- R8: A request is accepted only while idle. `h_ready` rises exactly two clock edges after the accepting edge and stays high for one cycle, and a request held high during the access is not accepted a second time.
- R9: During and after reset `h_ready` is low, `h_rdata` is zero and no target strobe is asserted.
- R10: Each accepted access to a valid target produces exactly one strobe on exactly one target, and completed writes return zero on `h_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host request, sampled while idle |
| h_we | input | 1 | 1 = write, 0 = read |
| h_addr | input | 7 | Byte address in the window |
| h_size | input | 3 | Access size in bytes (1-4) |
| h_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| h_rdata | output | 32 | Read data, valid with h_ready |
| h_ready | output | 1 | One-cycle completion pulse |
| core_en | output | 1 | Core bank access strobe |
| core_idx | output | 4 | Core word index for access and peek |
| core_rdata | input | 32 | Core read data (may have side effects) |
| core_pdata | input | 32 | Core peek data (no side effects) |
| dma_en | output | 1 | DMA bank access strobe |
| dma_idx | output | 3 | DMA word index for access and peek |
| dma_rdata | input | 32 | DMA read data (may have side effects) |
| dma_pdata | input | 32 | DMA peek data (no side effects) |
| ctl_en | output | 1 | Control register access strobe |
| ctl_rdata | input | 32 | Control register read data |
| ctl_pdata | input | 32 | Control register peek data |
| t_we | output | 1 | Write qualifier for the active strobe |
| t_wdata | output | 32 | Full merged write word |

## Verification
The bench goes after the seams between the read map and the write map. A byte write at 0x73 must land in the control register, while a read at 0x71 must return 0. A design that decoded both directions the same way would either lose the write or leak the register on the read. A byte write at 0x61 fetches from the control register but must still be dropped. A read-to-clear DMA register is written narrowly to show that a merge built on the normal read strobe would wipe its flag bits. Reads and writes that run past lane 3 are checked for the right shift and clipping. A request held high across the busy window is checked so that a design re-accepting it would show two strobes.

// File: rtl/swb_pkg.sv
package swb_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_CORE = 2'd1,
      TGT_DMA  = 2'd2,
      TGT_CTL  = 2'd3
   } swb_tgt_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_DONE = 2'd2
   } swb_state_e;

endpackage

// File: rtl/swb_decode.sv
module swb_decode
   import swb_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int BYTES      = 4,
   parameter int DMA_BASE   = 64,
   parameter int DMA_LIMIT  = 96,
   parameter int CTL_ADDR   = 112,
   parameter int PEEK_LIMIT = 116,
   parameter int CORE_IDX_W = 4,
   parameter int DMA_IDX_W  = 3
) (
   input  logic [ADDR_W-1:0]     addr,
   output swb_tgt_e              wr_tgt,
   output swb_tgt_e              rd_tgt,
   output swb_tgt_e              pk_tgt,
   output logic [CORE_IDX_W-1:0] core_idx,
   output logic [DMA_IDX_W-1:0]  dma_idx
);
   localparam int OFF_W = $clog2(BYTES);
   localparam logic [ADDR_W-1:0] DMA_B = ADDR_W'(DMA_BASE);
   localparam logic [ADDR_W-1:0] DMA_L = ADDR_W'(DMA_LIMIT);
   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
   localparam logic [ADDR_W-1:0] PK_L  = ADDR_W'(PEEK_LIMIT);

   logic [ADDR_W-1:0] aligned;

   // access map: the control register answers one exact address
   function automatic swb_tgt_e access_region(input logic [ADDR_W-1:0] a);
      if (a < DMA_B)       return TGT_CORE;
      else if (a < DMA_L)  return TGT_DMA;
      else if (a == CTL_A) return TGT_CTL;
      else                 return TGT_NONE;
   endfunction

   // peek map: the whole span below PK_L past the DMA bank reads control
   function automatic swb_tgt_e peek_region(input logic [ADDR_W-1:0] a);
      if (a < DMA_B)      return TGT_CORE;
      else if (a < DMA_L) return TGT_DMA;
      else if (a < PK_L)  return TGT_CTL;
      else                return TGT_NONE;
   endfunction

   always_comb begin
      aligned  = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      wr_tgt   = access_region(aligned);
      rd_tgt   = access_region(addr);
      pk_tgt   = peek_region(addr);
      core_idx = CORE_IDX_W'(addr >> OFF_W);
      dma_idx  = DMA_IDX_W'((addr - DMA_B) >> OFF_W);
   end

endmodule

// File: rtl/swb_merge.sv
module swb_merge #(
   parameter int DATA_W = 32,
   parameter int BYTES  = DATA_W / 8,
   parameter int OFF_W  = $clog2(BYTES),
   parameter int SIZE_W = $clog2(BYTES) + 1
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] wdata,
   input  logic [OFF_W-1:0]  off,
   input  logic [SIZE_W-1:0] size,
   output logic [DATA_W-1:0] merged
);
   logic [DATA_W-1:0] placed;

   assign placed = wdata << {off, 3'b000};

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      logic hit;
      assign hit = (int'(off) <= i) && (i < int'(off) + int'(size));
      assign merged[8*i +: 8] = hit ? placed[8*i +: 8] : cur[8*i +: 8];
   end

endmodule

// File: rtl/swb_rdalign.sv
module swb_rdalign #(
   parameter int DATA_W = 32,
   parameter int BYTES  = DATA_W / 8,
   parameter int OFF_W  = $clog2(BYTES),
   parameter int SIZE_W = $clog2(BYTES) + 1
) (
   input  logic [DATA_W-1:0] word,
   input  logic [OFF_W-1:0]  off,
   input  logic [SIZE_W-1:0] size,
   output logic [DATA_W-1:0] data
);
   logic [DATA_W-1:0] shifted;

   assign shifted = word >> {off, 3'b000};

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign data[8*i +: 8] = (i < int'(size)) ? shifted[8*i +: 8] : 8'h00;
   end

endmodule

// File: rtl/swb_bridge.sv
module swb_bridge
   import swb_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 7,
   parameter int DMA_BASE   = 64,
   parameter int DMA_LIMIT  = 96,
   parameter int CTL_ADDR   = 112,
   parameter int PEEK_LIMIT = 116,
   parameter int BYTES      = DATA_W / 8,
   parameter int SIZE_W     = $clog2(BYTES) + 1,
   parameter int CORE_IDX_W = $clog2(DMA_BASE / BYTES),
   parameter int DMA_IDX_W  = $clog2((DMA_LIMIT - DMA_BASE) / BYTES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  h_req,
   input  logic                  h_we,
   input  logic [ADDR_W-1:0]     h_addr,
   input  logic [SIZE_W-1:0]     h_size,
   input  logic [DATA_W-1:0]     h_wdata,
   output logic [DATA_W-1:0]     h_rdata,
   output logic                  h_ready,
   output logic                  core_en,
   output logic [CORE_IDX_W-1:0] core_idx,
   input  logic [DATA_W-1:0]     core_rdata,
   input  logic [DATA_W-1:0]     core_pdata,
   output logic                  dma_en,
   output logic [DMA_IDX_W-1:0]  dma_idx,
   input  logic [DATA_W-1:0]     dma_rdata,
   input  logic [DATA_W-1:0]     dma_pdata,
   output logic                  ctl_en,
   input  logic [DATA_W-1:0]     ctl_rdata,
   input  logic [DATA_W-1:0]     ctl_pdata,
   output logic                  t_we,
   output logic [DATA_W-1:0]     t_wdata
);
   localparam int OFF_W = $clog2(BYTES);

   // elaboration-time parameter checks
   if ((DATA_W % 8) != 0 || BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_width
      $error("swb_bridge: DATA_W must be a power-of-two number of bytes");
   end
   if (DMA_BASE <= 0 || DMA_BASE >= DMA_LIMIT || (DMA_BASE % BYTES) != 0) begin : g_bad_dma
      $error("swb_bridge: DMA window must be word aligned and non-empty");
   end
   if (CTL_ADDR < DMA_LIMIT || CTL_ADDR >= PEEK_LIMIT || (CTL_ADDR % BYTES) != 0) begin : g_bad_ctl
      $error("swb_bridge: control address must be aligned and inside the peek span");
   end
   if (PEEK_LIMIT > (1 << ADDR_W)) begin : g_bad_addr
      $error("swb_bridge: window does not fit ADDR_W");
   end

   swb_state_e        state;
   logic              q_we;
   logic [ADDR_W-1:0] q_addr;
   logic [SIZE_W-1:0] q_size;
   logic [DATA_W-1:0] q_wdata;
   logic [SIZE_W-1:0] size_n;
   logic              in_acc;

   swb_tgt_e          wr_tgt, rd_tgt, pk_tgt, act_tgt;
   logic [DATA_W-1:0] cur_word, rd_word, merged, rd_aligned;

   // out-of-range size codes collapse to a full word
   assign size_n = (h_size == '0 || int'(h_size) > BYTES) ? SIZE_W'(BYTES) : h_size;
   assign in_acc = (state == ST_ACC);

   swb_decode #(
      .ADDR_W(ADDR_W), .BYTES(BYTES), .DMA_BASE(DMA_BASE), .DMA_LIMIT(DMA_LIMIT),
      .CTL_ADDR(CTL_ADDR), .PEEK_LIMIT(PEEK_LIMIT),
      .CORE_IDX_W(CORE_IDX_W), .DMA_IDX_W(DMA_IDX_W)
   ) u_decode (
      .addr(q_addr), .wr_tgt(wr_tgt), .rd_tgt(rd_tgt), .pk_tgt(pk_tgt),
      .core_idx(core_idx), .dma_idx(dma_idx)
   );

   always_comb begin
      unique case (pk_tgt)
         TGT_CORE: cur_word = core_pdata;
         TGT_DMA:  cur_word = dma_pdata;
         TGT_CTL:  cur_word = ctl_pdata;
         default:  cur_word = '0;
      endcase
      unique case (rd_tgt)
         TGT_CORE: rd_word = core_rdata;
         TGT_DMA:  rd_word = dma_rdata;
         TGT_CTL:  rd_word = ctl_rdata;
         default:  rd_word = '0;
      endcase
   end

   swb_merge #(.DATA_W(DATA_W), .BYTES(BYTES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_merge (
      .cur(cur_word), .wdata(q_wdata), .off(q_addr[OFF_W-1:0]), .size(q_size),
      .merged(merged)
   );

   swb_rdalign #(.DATA_W(DATA_W), .BYTES(BYTES), .OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_rdalign (
      .word(rd_word), .off(q_addr[OFF_W-1:0]), .size(q_size), .data(rd_aligned)
   );

   // target strobes exist only in the access cycle
   assign act_tgt = q_we ? wr_tgt : rd_tgt;
   assign core_en = in_acc && (act_tgt == TGT_CORE);
   assign dma_en  = in_acc && (act_tgt == TGT_DMA);
   assign ctl_en  = in_acc && (act_tgt == TGT_CTL);
   assign t_we    = in_acc && q_we;
   assign t_wdata = merged;
   assign h_ready = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         q_we    <= 1'b0;
         q_addr  <= '0;
         q_size  <= SIZE_W'(BYTES);
         q_wdata <= '0;
         h_rdata <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (h_req) begin
               state   <= ST_ACC;
               q_we    <= h_we;
               q_addr  <= h_addr;
               q_size  <= size_n;
               q_wdata <= h_wdata;
            end
            ST_ACC: begin
               state   <= ST_DONE;
               h_rdata <= q_we ? '0 : rd_aligned;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({core_en, dma_en, ctl_en}));

   // R8
   fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && h_req) |=> ##1 h_ready);

   // R8
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_ready |=> !h_ready);

   // R6
   rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_ready && !q_we && int'(q_size) < BYTES) |-> ((h_rdata >> {q_size, 3'b000}) == '0));

   // R5
   rd_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_acc && !q_we && rd_tgt == TGT_NONE) |=> (h_rdata == '0));

   // R4
   wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_acc && q_we && wr_tgt == TGT_NONE) |-> !(core_en || dma_en || ctl_en));

   // R2
   keep_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (t_we && (core_en || dma_en || ctl_en) && q_addr[OFF_W-1:0] != '0)
         |-> (t_wdata[7:0] == cur_word[7:0]));

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!h_ready && h_rdata == '0 && !core_en && !dma_en && !ctl_en));

endmodule

// File: tb/swb_bridge_test.sv
module swb_bridge_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_req = 1'b0;
   logic        h_we = 1'b0;
   logic [6:0]  h_addr = '0;
   logic [2:0]  h_size = 3'd4;
   logic [31:0] h_wdata = '0;
   logic [31:0] h_rdata;
   logic        h_ready;
   logic        core_en, dma_en, ctl_en, t_we;
   logic [3:0]  core_idx;
   logic [2:0]  dma_idx;
   logic [31:0] core_rdata, core_pdata, dma_rdata, dma_pdata, ctl_rdata, ctl_pdata, t_wdata;

   logic [31:0] core_m [16];
   logic [31:0] dma_m [8];
   logic [31:0] ctl_m;
   int          strobe_cnt;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   swb_bridge uut (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
      .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
      .core_en(core_en), .core_idx(core_idx), .core_rdata(core_rdata), .core_pdata(core_pdata),
      .dma_en(dma_en), .dma_idx(dma_idx), .dma_rdata(dma_rdata), .dma_pdata(dma_pdata),
      .ctl_en(ctl_en), .ctl_rdata(ctl_rdata), .ctl_pdata(ctl_pdata),
      .t_we(t_we), .t_wdata(t_wdata)
   );

   // target models; DMA word 5 clears bits 3:1 when read through the access port
   assign core_rdata = core_m[core_idx];
   assign core_pdata = core_m[core_idx];
   assign dma_rdata  = dma_m[dma_idx];
   assign dma_pdata  = dma_m[dma_idx];
   assign ctl_rdata  = ctl_m;
   assign ctl_pdata  = ctl_m;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) core_m[i] <= '0;
         for (int i = 0; i < 8; i++) dma_m[i] <= '0;
         ctl_m      <= '0;
         strobe_cnt <= 0;
      end else begin
         if (core_en || dma_en || ctl_en) strobe_cnt <= strobe_cnt + 1;
         if (core_en && t_we) core_m[core_idx] <= t_wdata;
         if (dma_en && t_we) dma_m[dma_idx] <= t_wdata;
         if (dma_en && !t_we && dma_idx == 3'd5) dma_m[5] <= dma_m[5] & ~32'h0000_000E;
         if (ctl_en && t_we) ctl_m <= t_wdata;
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] merge_exp(input logic [31:0] cur, input logic [31:0] d,
                                             input int off, input int sz);
      logic [31:0] r = cur;
      for (int k = 0; k < sz; k++)
         if (off + k < 4) r[8*(off+k) +: 8] = d[8*k +: 8];
      return r;
   endfunction

   function automatic logic [31:0] rd_exp(input logic [31:0] w, input int off, input int sz);
      logic [31:0] s = w >> (8*off);
      logic [31:0] r = '0;
      for (int k = 0; k < sz && k < 4; k++) r[8*k +: 8] = s[8*k +: 8];
      return r;
   endfunction

   // one host access; checks the two-cycle completion (R8) and returns data and strobes
   task automatic xfer(input logic we, input logic [6:0] a, input logic [2:0] sz,
                       input logic [31:0] d, output logic [31:0] rd, output int strobes);
      int s0;
      @(negedge clk);
      h_req = 1'b1; h_we = we; h_addr = a; h_size = sz; h_wdata = d;
      s0 = strobe_cnt;
      @(negedge clk);
      h_req = 1'b0;
      chk("R8 ready low in access cycle", {31'b0, h_ready}, 32'd0);
      @(negedge clk);
      chk("R8 ready after two edges", {31'b0, h_ready}, 32'd1);
      rd = h_rdata;
      strobes = strobe_cnt - s0;
   endtask

   task automatic wr(input logic [6:0] a, input logic [2:0] sz, input logic [31:0] d,
                     input int exp_strobes);
      logic [31:0] rd;
      int st;
      xfer(1'b1, a, sz, d, rd, st);
      chk("R10 write strobes", st, exp_strobes);
      chk("R10 write returns zero", rd, 32'd0);
   endtask

   task automatic rd_chk(input string req, input logic [6:0] a, input logic [2:0] sz,
                         input logic [31:0] exp, input int exp_strobes);
      logic [31:0] rd;
      int st;
      xfer(1'b0, a, sz, 32'hDEAD_BEEF, rd, st);
      chk(req, rd, exp);
      chk("R10 read strobes", st, exp_strobes);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R9 ready in reset", {31'b0, h_ready}, 32'd0);
      chk("R9 rdata in reset", h_rdata, 32'd0);
      chk("R9 strobes in reset", {29'b0, core_en, dma_en, ctl_en}, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 quiet after reset", {30'b0, h_ready, core_en | dma_en | ctl_en}, 32'd0);
   endtask

   task automatic t_full_map();
      wr(7'h0C, 3'd4, 32'h1122_3344, 1);
      chk("R1 core word 3", core_m[3], 32'h1122_3344);
      rd_chk("R1 core readback", 7'h0C, 3'd4, 32'h1122_3344, 1);
      wr(7'h48, 3'd4, 32'hA5A5_0001, 1);
      chk("R1 dma word 2", dma_m[2], 32'hA5A5_0001);
      rd_chk("R1 dma readback", 7'h48, 3'd4, 32'hA5A5_0001, 1);
      wr(7'h70, 3'd4, 32'hCAFE_0070, 1);
      chk("R1 control word", ctl_m, 32'hCAFE_0070);
      rd_chk("R1 control readback", 7'h70, 3'd4, 32'hCAFE_0070, 1);
   endtask

   task automatic t_merge();
      logic [31:0] e;
      wr(7'h20, 3'd4, 32'h8899_AABB, 1);
      e = merge_exp(32'h8899_AABB, 32'h0000_005C, 2, 1);
      wr(7'h22, 3'd1, 32'h0000_005C, 1);
      chk("R2 byte lane 2", core_m[8], e);
      e = merge_exp(e, 32'h0000_1234, 1, 2);
      wr(7'h21, 3'd2, 32'h0000_1234, 1);
      chk("R2 half at offset 1", core_m[8], e);
      e = merge_exp(e, 32'hDDCC_BBEE, 3, 4);
      wr(7'h23, 3'd4, 32'hDDCC_BBEE, 1);
      chk("R2 word clipped at lane 3", core_m[8], e);
      wr(7'h3D, 3'd2, 32'h0000_ABCD, 1);
      chk("R2 top core word", core_m[15], 32'h00AB_CD00);
   endtask

   task automatic t_peek();
      wr(7'h54, 3'd4, 32'h0000_00FF, 1);
      wr(7'h56, 3'd1, 32'h0000_0077, 1);
      chk("R3 narrow write keeps read-to-clear bits", dma_m[5], 32'h0077_00FF);
      rd_chk("R3 read sees flags", 7'h54, 3'd4, 32'h0077_00FF, 1);
      chk("R3 real read clears flags", dma_m[5], 32'h0077_00F1);
      wr(7'h73, 3'd1, 32'h0000_00AB, 1);
      chk("R3 byte at 0x73 merges control", ctl_m, 32'hABFE_0070);
   endtask

   task automatic t_invalid();
      wr(7'h61, 3'd1, 32'h0000_0055, 0);
      chk("R4 drop at 0x61 control", ctl_m, 32'hABFE_0070);
      rd_chk("R4 drop at 0x61 dma", 7'h5C, 3'd4, 32'd0, 1);
      wr(7'h7C, 3'd4, 32'hFFFF_FFFF, 0);
      chk("R4 drop at 0x7C control", ctl_m, 32'hABFE_0070);
      rd_chk("R5 read 0x71 is zero", 7'h71, 3'd1, 32'd0, 0);
      rd_chk("R5 read 0x72 is zero", 7'h72, 3'd2, 32'd0, 0);
      rd_chk("R5 read 0x64 is zero", 7'h64, 3'd4, 32'd0, 0);
      rd_chk("R5 read 0x7C is zero", 7'h7C, 3'd4, 32'd0, 0);
   endtask

   task automatic t_read_align();
      wr(7'h10, 3'd4, 32'hA1B2_C3D4, 1);
      rd_chk("R6 byte at offset 3", 7'h13, 3'd1, rd_exp(32'hA1B2_C3D4, 3, 1), 1);
      rd_chk("R6 half at offset 1", 7'h11, 3'd2, rd_exp(32'hA1B2_C3D4, 1, 2), 1);
      rd_chk("R6 word at offset 2", 7'h12, 3'd4, rd_exp(32'hA1B2_C3D4, 2, 4), 1);
      rd_chk("R6 three bytes", 7'h10, 3'd3, rd_exp(32'hA1B2_C3D4, 0, 3), 1);
      rd_chk("R6 dma byte offset 2", 7'h56, 3'd1, 32'h0000_0077, 1);
   endtask

   task automatic t_size_codes();
      rd_chk("R7 size 0 reads a word", 7'h10, 3'd0, 32'hA1B2_C3D4, 1);
      rd_chk("R7 size 7 reads a word", 7'h10, 3'd7, 32'hA1B2_C3D4, 1);
      wr(7'h14, 3'd0, 32'h0102_0304, 1);
      chk("R7 size 0 writes a word", core_m[5], 32'h0102_0304);
      wr(7'h15, 3'd5, 32'h0A0B_0C0D, 1);
      chk("R7 size 5 acts as 4", core_m[5], merge_exp(32'h0102_0304, 32'h0A0B_0C0D, 1, 4));
   endtask

   task automatic t_held_request();
      int s0;
      @(negedge clk);
      h_req = 1'b1; h_we = 1'b1; h_addr = 7'h04; h_size = 3'd4; h_wdata = 32'h5555_AAAA;
      s0 = strobe_cnt;
      @(negedge clk);
      h_wdata = 32'h0F0F_0F0F;
      @(negedge clk);
      h_req = 1'b0;
      chk("R8 ready with held request", {31'b0, h_ready}, 32'd1);
      @(negedge clk);
      chk("R8 ready is a one-cycle pulse", {31'b0, h_ready}, 32'd0);
      chk("R8 held request accepted once", strobe_cnt - s0, 32'd1);
      chk("R8 first data kept", core_m[1], 32'h5555_AAAA);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_full_map();
      t_merge();
      t_peek();
      t_invalid();
      t_read_align();
      t_size_codes();
      t_held_request();
      repeat (2) @(negedge clk);
      finished = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
      end
   end

endmodule